// File: doc/BRIEF.md
# Triple-Error Table Decoder for a (15,5) Binary BCH Code

This block decodes 15-bit received words of a systematic (15,5) binary BCH code with minimum distance 7 and repairs up to three flipped bits without any iterative error-locator search. The first five bits of a word carry the message and the remaining ten carry parity. The decoder forms a 10-bit syndrome and counts its ones. When the count is three or less, every error must sit in the parity field, so the syndrome itself is the parity correction. Otherwise the syndrome is compared with 25 constant syndromes, one for each way of flipping one, two or three message bits. The weight of each XOR difference shows whether that message pattern plus a few parity flips accounts for the syndrome.

Words enter with a valid strobe, one per clock if required. The corrected word, its message field, the number of bits flipped and a status code come out two clocks later. Bit numbering follows the written order: `in_word[14]` is bit 1 (first message bit) and `in_word[0]` is bit 15 (last parity bit). The code is generated by x^10+x^8+x^5+x^4+x^2+x+1 in systematic form. Message 00001 encodes to 000011101100101, and an error in bit 1 gives syndrome 1110110010.

Top module: `bch15_lut_decoder`

## Requirements
- R1: After synchronous reset, `out_valid` is low and stays low until a valid word has travelled through both pipeline stages.
- R2: A word presented with `in_valid` high at a rising edge appears with `out_valid` high exactly two rising edges later, and a word is accepted on every cycle. A cycle with `in_valid` low gives `out_valid` low two edges later.
- R3: A codeword received without error is passed through unchanged with `out_status` = 0 (clean) and `out_nerr` = 0.
- R4: When one to three errors lie only in bits 6 to 15, the output is the transmitted codeword, `out_status` = 1 (corrected) and `out_nerr` equals the number of flipped bits.
- R5: When one to three errors include at least one of bits 1 to 5, the output is the transmitted codeword, `out_status` = 1 and `out_nerr` equals the total number of flipped bits.
- R6: The received word 100010101110101 decodes to 000011101100101 with message 00001, status 1 and three flipped bits.
- R7: A word with no codeword within Hamming distance 3 is passed through unchanged with `out_status` = 2 (uncorrectable) and `out_nerr` = 0.
- R8: `out_msg` always equals the first five bits (`out_word[14:10]`) of the output word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Received word is present this cycle |
| in_word | input | 15 | Received word, bit 1 in position 14 |
| out_valid | output | 1 | Decoded result is present this cycle |
| out_word | output | 15 | Corrected (or passed-through) word |
| out_msg | output | 5 | Message field of the output word |
| out_nerr | output | 2 | Number of bits flipped by the decoder |
| out_status | output | 2 | 0 clean, 1 corrected, 2 uncorrectable |

## Verification
On every cycle the assertions check the two-edge valid latency, that every non-uncorrectable output is a true codeword, that the flip count matches the Hamming distance between input and output, that uncorrectable words leave untouched and that the message field tracks the output word. Whether a corrected output is the right codeword, rather than merely some codeword, can only be shown by the bench, which encodes random messages, injects zero to five errors and compares with a brute-force nearest-codeword search over all 32 codewords. The worked vector and deliberately uncorrectable words are driven as directed cases.

// File: rtl/bch15_pkg.sv
package bch15_pkg;

    localparam int CW_W   = 15;
    localparam int MSG_W  = 5;
    localparam int PAR_W  = CW_W - MSG_W;
    localparam int MAX_T  = 3;
    localparam int CNT_W  = $clog2(MAX_T + 1);
    localparam int SW_W   = $clog2(PAR_W + 1);
    localparam int N_PAIR = MSG_W * (MSG_W - 1) / 2;
    localparam int N_TRIP = MSG_W * (MSG_W - 1) * (MSG_W - 2) / 6;
    localparam int TBL_N  = MSG_W + N_PAIR + N_TRIP;

    typedef logic [CW_W-1:0]  word_t;
    typedef logic [PAR_W-1:0] syn_t;
    typedef logic [CNT_W-1:0] cnt_t;
    typedef logic [SW_W-1:0]  sw_t;

    typedef enum logic [1:0] {
        ST_CLEAN  = 2'd0,
        ST_FIXED  = 2'd1,
        ST_UNCORR = 2'd2
    } status_e;

    // One table row: syndrome of a message-field error pattern.
    typedef struct packed {
        syn_t  syn;
        word_t err;
        cnt_t  nbits;
    } entry_t;

    typedef entry_t [TBL_N-1:0] table_t;

    // Parity contribution of each message bit; index 0 is bit 1.
    localparam logic [MSG_W-1:0][PAR_W-1:0] PAR_ROWS = {
        10'b1101100101,
        10'b0110101111,
        10'b1101011110,
        10'b0111011001,
        10'b1110110010
    };

    function automatic syn_t calc_syndrome(word_t w);
        syn_t s;
        s = w[PAR_W-1:0];
        for (int m = 0; m < MSG_W; m++) begin
            if (w[CW_W-1-m]) s = s ^ PAR_ROWS[m];
        end
        return s;
    endfunction

    function automatic word_t msg_bit(int m);
        word_t w;
        w = '0;
        w[CW_W-1-m] = 1'b1;
        return w;
    endfunction

    function automatic entry_t mk_entry(word_t e, int n);
        entry_t r;
        r.err   = e;
        r.syn   = calc_syndrome(e);
        r.nbits = cnt_t'(n);
        return r;
    endfunction

    // Rows ordered by pattern weight, then lexicographically by bit index.
    function automatic table_t build_table();
        table_t t;
        int idx;
        idx = 0;
        for (int a = 0; a < MSG_W; a++) begin
            t[idx] = mk_entry(msg_bit(a), 1);
            idx++;
        end
        for (int a = 0; a < MSG_W; a++) begin
            for (int b = a + 1; b < MSG_W; b++) begin
                t[idx] = mk_entry(msg_bit(a) | msg_bit(b), 2);
                idx++;
            end
        end
        for (int a = 0; a < MSG_W; a++) begin
            for (int b = a + 1; b < MSG_W; b++) begin
                for (int c = b + 1; c < MSG_W; c++) begin
                    t[idx] = mk_entry(msg_bit(a) | msg_bit(b) | msg_bit(c), 3);
                    idx++;
                end
            end
        end
        return t;
    endfunction

    localparam table_t LUT = build_table();

endpackage

// File: rtl/bch15_syndrome.sv
module bch15_syndrome
    import bch15_pkg::*;
(
    input  word_t rx,
    output syn_t  syn,
    output sw_t   syn_wt
);
    always_comb begin
        syn    = calc_syndrome(rx);
        syn_wt = sw_t'($countones(syn));
    end
endmodule

// File: rtl/bch15_diff_bank.sv
module bch15_diff_bank
    import bch15_pkg::*;
(
    input  syn_t                         syn,
    output logic [TBL_N-1:0][CNT_W-1:0] dwt
);
    for (genvar i = 0; i < TBL_N; i++) begin : g_row
        syn_t diff;
        sw_t  w;
        assign diff = syn ^ LUT[i].syn;
        assign w    = sw_t'($countones(diff));
        // Saturate: anything above MAX_T can never qualify.
        assign dwt[i] = (w > sw_t'(MAX_T)) ? cnt_t'(MAX_T) : w[CNT_W-1:0];
    end
endmodule

// File: rtl/bch15_select.sv
module bch15_select
    import bch15_pkg::*;
(
    input  syn_t                         syn,
    input  logic [TBL_N-1:0][CNT_W-1:0] dwt,
    output logic                         hit,
    output word_t                        corr
);
    logic [TBL_N-1:0] qual;

    for (genvar i = 0; i < TBL_N; i++) begin : g_qual
        logic [CNT_W:0] budget;
        assign budget  = {1'b0, dwt[i]} + {1'b0, LUT[i].nbits};
        assign qual[i] = (budget <= (CNT_W+1)'(MAX_T));
    end

    // Scan from the top so the lowest qualifying index wins.
    always_comb begin
        hit  = 1'b0;
        corr = '0;
        for (int i = TBL_N - 1; i >= 0; i--) begin
            if (qual[i]) begin
                hit  = 1'b1;
                corr = LUT[i].err ^ {{MSG_W{1'b0}}, syn ^ LUT[i].syn};
            end
        end
    end
endmodule

// File: rtl/bch15_lut_decoder.sv
module bch15_lut_decoder
    import bch15_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             in_valid,
    input  logic [14:0]      in_word,
    output logic             out_valid,
    output logic [14:0]      out_word,
    output logic [4:0]       out_msg,
    output logic [1:0]       out_nerr,
    output logic [1:0]       out_status
);
    typedef struct packed {
        logic  vld;
        word_t rx;
        syn_t  syn;
        sw_t   wt;
    } s1_t;

    syn_t                         syn_c;
    sw_t                          wt_c;
    logic [TBL_N-1:0][CNT_W-1:0]  dwt_c;
    s1_t                          s1_q;
    logic [TBL_N-1:0][CNT_W-1:0]  dwt_q;

    bch15_syndrome u_syn (
        .rx     (in_word),
        .syn    (syn_c),
        .syn_wt (wt_c)
    );

    bch15_diff_bank u_bank (
        .syn (syn_c),
        .dwt (dwt_c)
    );

    // Stage 1: syndrome, its weight and the difference weights.
    always_ff @(posedge clk) begin
        if (rst) begin
            s1_q  <= '0;
            dwt_q <= '0;
        end else begin
            s1_q.vld <= in_valid;
            s1_q.rx  <= in_word;
            s1_q.syn <= syn_c;
            s1_q.wt  <= wt_c;
            dwt_q    <= dwt_c;
        end
    end

    logic    hit;
    word_t   tbl_corr;
    word_t   corr;
    status_e st;

    bch15_select u_sel (
        .syn  (s1_q.syn),
        .dwt  (dwt_q),
        .hit  (hit),
        .corr (tbl_corr)
    );

    always_comb begin
        if (s1_q.wt == '0) begin
            corr = '0;
            st   = ST_CLEAN;
        end else if (s1_q.wt <= sw_t'(MAX_T)) begin
            corr = {{MSG_W{1'b0}}, s1_q.syn};
            st   = ST_FIXED;
        end else if (hit) begin
            corr = tbl_corr;
            st   = ST_FIXED;
        end else begin
            corr = '0;
            st   = ST_UNCORR;
        end
    end

    // Stage 2: corrected word and status.
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_word   <= '0;
            out_msg    <= '0;
            out_nerr   <= '0;
            out_status <= ST_CLEAN;
        end else begin
            out_valid  <= s1_q.vld;
            out_word   <= s1_q.rx ^ corr;
            out_msg    <= s1_q.rx[CW_W-1:PAR_W] ^ corr[CW_W-1:PAR_W];
            out_nerr   <= cnt_t'($countones(corr));
            out_status <= st;
        end
    end

endmodule

// File: rtl/bch15_lut_decoder_chk.sv
module bch15_lut_decoder_chk
    import bch15_pkg::*;
(
    input logic        clk,
    input logic        rst,
    input logic        in_valid,
    input logic [14:0] in_word,
    input logic        out_valid,
    input logic [14:0] out_word,
    input logic [4:0]  out_msg,
    input logic [1:0]  out_nerr,
    input logic [1:0]  out_status
);
    logic [1:0] age;

    always_ff @(posedge clk) begin
        if (rst)            age <= 2'd0;
        else if (age != 2'd3) age <= age + 2'd1;
    end

    AST_IDLE_AFTER_RESET: assert property (@(posedge clk) disable iff (rst)
        (age < 2'd2) |-> !out_valid); // R1
    AST_TWO_EDGE_LATENCY: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2) |-> (out_valid == $past(in_valid, 2))); // R2
    AST_CLEAN_NO_FLIPS: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_status == 2'd0) |-> (out_nerr == 2'd0)); // R3
    AST_FLIPS_MATCH_DIST: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2 && out_valid) |->
        ($countones(out_word ^ $past(in_word, 2)) == int'(out_nerr))); // R4
    AST_RESULT_IS_CODEWORD: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_status != 2'd2) |-> (calc_syndrome(out_word) == '0)); // R5
    AST_UNCORR_PASSTHRU: assert property (@(posedge clk) disable iff (rst)
        (age >= 2'd2 && out_valid && out_status == 2'd2) |->
        (out_word == $past(in_word, 2) && out_nerr == 2'd0)); // R7
    AST_MSG_FIELD: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (out_msg == out_word[14:10])); // R8

endmodule

bind bch15_lut_decoder bch15_lut_decoder_chk u_chk (.*);

// File: tb/tb_bch15_lut_decoder.sv
module tb_bch15_lut_decoder;

    logic        clk = 1'b0;
    logic        rst;
    logic        in_valid;
    logic [14:0] in_word;
    logic        out_valid;
    logic [14:0] out_word;
    logic [4:0]  out_msg;
    logic [1:0]  out_nerr;
    logic [1:0]  out_status;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    bch15_lut_decoder dut (.*);

    // Generator polynomial, bit d = coefficient of x^d.
    localparam logic [10:0] GPOLY = 11'b10100110111;

    logic [14:0] code_tab [32];

    // x^k * g(x); word position 14-d holds coefficient of x^d.
    function automatic logic [14:0] shifted_g(int k);
        logic [14:0] w;
        w = '0;
        for (int d = 0; d <= 10; d++)
            if (GPOLY[d]) w[14 - (d + k)] = 1'b1;
        return w;
    endfunction

    task automatic build_codes();
        for (int c = 0; c < 32; c++) begin
            logic [14:0] w;
            w = '0;
            for (int k = 0; k < 5; k++)
                if (c[k]) w = w ^ shifted_g(k);
            code_tab[w[14:10]] = w;
        end
    endtask

    function automatic int hdist(logic [14:0] a, logic [14:0] b);
        return $countones(a ^ b);
    endfunction

    // Brute-force nearest codeword within radius 3.
    task automatic ref_decode(input logic [14:0] r, output logic [14:0] w,
                              output logic [1:0] st, output logic [1:0] n);
        w = r; st = 2'd2; n = 2'd0;
        for (int c = 0; c < 32; c++) begin
            int d;
            d = hdist(r, code_tab[c]);
            if (d <= 3) begin
                w  = code_tab[c];
                n  = 2'(d);
                st = (d == 0) ? 2'd0 : 2'd1;
            end
        end
    endtask

    typedef struct {
        bit          v;
        logic [14:0] w;
        logic [1:0]  st;
        logic [1:0]  n;
        string       tag;
    } exp_t;

    exp_t h1, h2;
    int seen_clean = 0, seen_par = 0, seen_msg = 0, seen_unc = 0;

    task automatic check_out(exp_t e);
        checks++;
        if (out_valid !== e.v) begin
            errors++;
            $display("FAIL R2 out_valid actual %0b expected %0b", out_valid, e.v);
        end
        if (e.v) begin
            checks++;
            if (out_word !== e.w || out_status !== e.st || out_nerr !== e.n) begin
                errors++;
                $display("FAIL %s word/status/nerr actual %b/%0d/%0d expected %b/%0d/%0d",
                         e.tag, out_word, out_status, out_nerr, e.w, e.st, e.n);
            end
            checks++;
            if (out_msg !== e.w[14:10]) begin
                errors++;
                $display("FAIL R8 out_msg actual %b expected %b", out_msg, e.w[14:10]);
            end
        end
    endtask

    // Drive at a falling edge; results for it are checked two falling edges later.
    task automatic step(bit v, logic [14:0] r, logic [14:0] tx);
        exp_t e;
        @(negedge clk);
        if (!rst) check_out(h2);
        e.v = v;
        e.tag = "R2";
        ref_decode(r, e.w, e.st, e.n);
        if (v) begin
            if (e.st == 2'd0) begin e.tag = "R3"; seen_clean++; end
            else if (e.st == 2'd2) begin e.tag = "R7"; seen_unc++; end
            else if (((r ^ tx) & 15'h7C00) == '0 && e.w == tx) begin e.tag = "R4"; seen_par++; end
            else begin e.tag = "R5"; seen_msg++; end
        end
        h2 = h1;
        h1 = e;
        in_valid = v;
        in_word  = r;
    endtask

    function automatic logic [14:0] inject(logic [14:0] c, int nerr);
        logic [14:0] e;
        e = '0;
        while ($countones(e) < nerr) e[$urandom_range(14, 0)] = 1'b1;
        return c ^ e;
    endfunction

    initial begin
        void'($urandom(32'd20517));
        build_codes();
        h1 = '{v: 1'b0, w: '0, st: '0, n: '0, tag: "R2"};
        h2 = h1;
        rst = 1'b1;
        in_valid = 1'b1;
        in_word = 15'h7FFF;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        in_valid = 1'b0;
        in_word = '0;

        // R1: idle right after reset
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0) begin
            errors++;
            $display("FAIL R1 out_valid actual %0b expected 0", out_valid);
        end

        // R6: worked vector
        step(1'b1, 15'b100010101110101, 15'b000011101100101);
        step(1'b0, '0, '0);
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b1 || out_word !== 15'b000011101100101 || out_msg !== 5'b00001 ||
            out_status !== 2'd1 || out_nerr !== 2'd3) begin
            errors++;
            $display("FAIL R6 word %b msg %b st %0d n %0d expected 000011101100101 00001 1 3",
                     out_word, out_msg, out_status, out_nerr);
        end
        h1.v = 1'b0; h2.v = 1'b0;
        in_valid = 1'b0;
        @(negedge clk);

        // Directed: every single-bit error on the all-ones-message codeword (R4, R5)
        for (int b = 0; b < 15; b++)
            step(1'b1, code_tab[5'h1F] ^ (15'd1 << b), code_tab[5'h1F]);
        // Directed: clean words back to back (R3)
        for (int m = 0; m < 32; m++) step(1'b1, code_tab[m], code_tab[m]);
        // Directed: uncorrectable words (R7)
        for (int t = 0, k = 0; t < 4000 && k < 6; t++) begin
            logic [14:0] r, w;
            logic [1:0] s, n;
            r = 15'($urandom);
            ref_decode(r, w, s, n);
            if (s == 2'd2) begin step(1'b1, r, r); k++; end
        end

        // Random mix with bubbles
        for (int i = 0; i < 4000; i++) begin
            logic [14:0] c;
            c = code_tab[$urandom_range(31, 0)];
            step(($urandom_range(7, 0) != 0), inject(c, $urandom_range(5, 0)), c);
        end
        step(1'b0, '0, '0);
        step(1'b0, '0, '0);
        step(1'b0, '0, '0);

        checks++;
        if (seen_clean == 0 || seen_par == 0 || seen_msg == 0 || seen_unc == 0) begin
            errors++;
            $display("FAIL R3 R4 R5 R7 coverage actual %0d/%0d/%0d/%0d expected all nonzero",
                     seen_clean, seen_par, seen_msg, seen_unc);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R2 watchdog actual hung expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule